// File: doc/BRIEF.md
# Speculation and Predication Shadow Unit

This block keeps track of shadows placed over function units that were issued ahead of a decision. The decision is either a branch outcome or a vector predicate mask. Each shadow lives in its own slot. A slot records which units depend on it and whether it waits on a branch or on a predicate.

While a shadow is open, every unit it covers sees its hold line asserted. A held unit must not commit its result. When the decision arrives, the resolve port names the slot.

- A branch slot either releases all of its units (correct prediction) or cancels all of them (misprediction).
- A predicate slot applies the mask bit by bit. A one releases the unit for that element. A zero sends that unit a go-die cancel.

Cancelled units are also removed from any other open shadow. The slot is then free to be allocated again.

Top module: `shadow_unit`

## Requirements
- R1: After a synchronous active-high reset, no slot is busy, hold and go_die are all zero, and alloc_ready is 1.
- R2: An allocation is placed in the lowest-numbered free slot, and alloc_slot shows that index in the same cycle. When every slot is busy, alloc_ready is 0 and an allocation request changes nothing.
- R3: From the cycle after an allocation, hold is asserted for each unit in the allocated set. Hold for a unit is the OR over all busy slots that cover it, so releasing one shadow leaves the unit held if another still covers it.
- R4: A predicate slot is allocated with alloc_kind = 1. On resolve, each covered unit whose pred_mask bit is 0 receives go_die, and each covered unit whose bit is 1 is released without go_die. Units the slot does not cover receive nothing, whatever the mask.
- R5: A branch slot is allocated with alloc_kind = 0. On resolve with resolve_mispredict = 1, every covered unit receives go_die. With resolve_mispredict = 0, every covered unit is released without go_die. pred_mask has no effect on a branch slot.
- R6: go_die is a one-cycle pulse in the cycle after the resolve edge, and it is zero in the following cycle unless another resolve occurs.
- R7: A resolved slot reads as not busy in the cycle after the resolve, and it can be allocated again.
- R8: A resolve naming a slot that is not busy has no effect: no go_die, and hold and slot_busy are unchanged.
- R9: A unit cancelled by one shadow is dropped from every other open shadow, so its hold falls in the same cycle its go_die pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to open a shadow |
| alloc_kind | input | 1 | 0 = branch shadow, 1 = predicate shadow |
| alloc_fus | input | NFU | Units covered by the new shadow |
| alloc_ready | output | 1 | At least one slot is free |
| alloc_slot | output | SW | Index the allocation would take |
| resolve_valid | input | 1 | Decision available for a slot |
| resolve_slot | input | SW | Slot being resolved |
| resolve_mispredict | input | 1 | Branch outcome was mispredicted |
| pred_mask | input | NFU | Decoded predicate mask, one bit per unit |
| hold | output | NFU | Per-unit commit block |
| go_die | output | NFU | Per-unit cancel pulse |
| slot_busy | output | NSLOT | Occupancy of each slot |

## Verification
The bench builds the block with its defaults: two slots and eight function units. With two slots, a full condition is reached after only two allocations. This makes the ignored third request observable, along with nested shadows that overlap on some units, so the cross-slot cancel and the OR of holds can both be exercised. Eight units allow byte-wide masks with mixed patterns, in which covered and uncovered bits differ inside one resolve.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;

    typedef enum logic {
        SHK_BRANCH = 1'b0,
        SHK_PRED   = 1'b1
    } shadow_kind_e;

    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/shadow_pick.sv
`timescale 1ns/1ps
module shadow_pick #(
    parameter int N = 2,
    parameter int W = 1
) (
    input  logic [N-1:0] free_vec,
    output logic         found,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign onehot[g]  = free_vec[g] & ~seen[g];
            assign seen[g+1]  = seen[g] | free_vec[g];
        end
    endgenerate

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | W'(i);
        end
    end
endmodule

// File: rtl/shadow_slot.sv
`timescale 1ns/1ps
module shadow_slot
    import shadow_pkg::*;
#(
    parameter int NFU = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_hit,
    input  shadow_kind_e       alloc_kind,
    input  logic [NFU-1:0]     alloc_fus,
    input  logic               release_hit,
    input  logic [NFU-1:0]     cancel_fus,
    output logic               busy,
    output shadow_kind_e       kind,
    output logic [NFU-1:0]     fus
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            kind <= SHK_BRANCH;
            fus  <= '0;
        end else if (alloc_hit) begin
            busy <= 1'b1;
            kind <= alloc_kind;
            fus  <= alloc_fus;
        end else if (release_hit) begin
            busy <= 1'b0;
            fus  <= '0;
        end else begin
            fus  <= fus & ~cancel_fus;
        end
    end

    a_r2_alloc_only_free: assert property (@(posedge clk) disable iff (rst)
        alloc_hit |-> !busy);

    a_r7_free_after_resolve: assert property (@(posedge clk) disable iff (rst)
        release_hit |=> !busy);

    a_r9_cancel_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && !alloc_hit && !release_hit) |=> ((fus & $past(cancel_fus)) == '0));
endmodule

// File: rtl/shadow_resolve.sv
`timescale 1ns/1ps
module shadow_resolve #(
    parameter int NSLOT = 2,
    parameter int NFU   = 8,
    parameter int SW    = 1
) (
    input  logic [NSLOT-1:0]     busy,
    input  logic [NSLOT-1:0]     is_pred,
    input  logic [NSLOT*NFU-1:0] fus_flat,
    input  logic                 resolve_valid,
    input  logic [SW-1:0]        resolve_slot,
    input  logic                 mispredict,
    input  logic [NFU-1:0]       pred_mask,
    output logic                 accept,
    output logic [NSLOT-1:0]     release_vec,
    output logic [NFU-1:0]       die_fus
);
    logic           in_range;
    logic [NFU-1:0] sel_fus;

    assign in_range = ({1'b0, resolve_slot} < (SW+1)'(NSLOT));

    always_comb begin
        accept      = 1'b0;
        sel_fus     = '0;
        die_fus     = '0;
        release_vec = '0;
        if (resolve_valid && in_range) begin
            accept = busy[resolve_slot];
        end
        if (accept) begin
            sel_fus                   = fus_flat[resolve_slot*NFU +: NFU];
            release_vec[resolve_slot] = 1'b1;
            if (is_pred[resolve_slot]) begin
                die_fus = sel_fus & ~pred_mask;
            end else if (mispredict) begin
                die_fus = sel_fus;
            end
        end
    end
endmodule

// File: rtl/shadow_unit.sv
`timescale 1ns/1ps
module shadow_unit
    import shadow_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int NFU   = 8,
    parameter int SW    = idx_width(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic             alloc_kind,
    input  logic [NFU-1:0]   alloc_fus,
    output logic             alloc_ready,
    output logic [SW-1:0]    alloc_slot,
    input  logic             resolve_valid,
    input  logic [SW-1:0]    resolve_slot,
    input  logic             resolve_mispredict,
    input  logic [NFU-1:0]   pred_mask,
    output logic [NFU-1:0]   hold,
    output logic [NFU-1:0]   go_die,
    output logic [NSLOT-1:0] slot_busy
);
    logic [NSLOT-1:0]     busy;
    logic [NSLOT-1:0]     is_pred;
    logic [NSLOT*NFU-1:0] fus_flat;
    logic [NSLOT-1:0]     pick_onehot;
    logic                 pick_found;
    logic                 alloc_fire;
    logic                 res_accept;
    logic [NSLOT-1:0]     release_vec;
    logic [NFU-1:0]       die_fus;
    logic [NFU-1:0]       die_q;
    shadow_kind_e         new_kind;

    assign new_kind = alloc_kind ? SHK_PRED : SHK_BRANCH;

    shadow_pick #(.N(NSLOT), .W(SW)) u_pick (
        .free_vec (~busy),
        .found    (pick_found),
        .idx      (alloc_slot),
        .onehot   (pick_onehot)
    );

    assign alloc_ready = pick_found;
    assign alloc_fire  = alloc_valid & pick_found;

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            shadow_kind_e   k;
            logic [NFU-1:0] f;
            shadow_slot #(.NFU(NFU)) u_slot (
                .clk         (clk),
                .rst         (rst),
                .alloc_hit   (alloc_fire & pick_onehot[s]),
                .alloc_kind  (new_kind),
                .alloc_fus   (alloc_fus),
                .release_hit (release_vec[s]),
                .cancel_fus  (die_fus),
                .busy        (busy[s]),
                .kind        (k),
                .fus         (f)
            );
            assign is_pred[s]              = (k == SHK_PRED);
            assign fus_flat[s*NFU +: NFU]  = f;
        end
    endgenerate

    shadow_resolve #(.NSLOT(NSLOT), .NFU(NFU), .SW(SW)) u_res (
        .busy          (busy),
        .is_pred       (is_pred),
        .fus_flat      (fus_flat),
        .resolve_valid (resolve_valid),
        .resolve_slot  (resolve_slot),
        .mispredict    (resolve_mispredict),
        .pred_mask     (pred_mask),
        .accept        (res_accept),
        .release_vec   (release_vec),
        .die_fus       (die_fus)
    );

    always_ff @(posedge clk) begin
        if (rst) die_q <= '0;
        else     die_q <= die_fus;
    end

    always_comb begin
        hold = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (busy[i]) hold = hold | fus_flat[i*NFU +: NFU];
        end
    end

    assign go_die    = die_q;
    assign slot_busy = busy;

    a_r6_die_follows_resolve: assert property (@(posedge clk) disable iff (rst)
        (|go_die) |-> $past(resolve_valid));

    a_r4_die_was_held: assert property (@(posedge clk) disable iff (rst)
        (go_die & ~$past(hold)) == '0);

    a_r9_killed_not_held: assert property (@(posedge clk) disable iff (rst)
        !$past(alloc_fire) |-> ((go_die & hold) == '0));

    a_r8_idle_no_die: assert property (@(posedge clk) disable iff (rst)
        (resolve_valid && !res_accept) |=> (go_die == '0));
endmodule

// File: tb/tb_shadow_unit.sv
`timescale 1ns/1ps
module tb_shadow_unit;
    localparam int NSLOT = 2;
    localparam int NFU   = 8;
    localparam int SW    = 1;
    localparam int NVEC  = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             alloc_valid;
    logic             alloc_kind;
    logic [NFU-1:0]   alloc_fus;
    logic             alloc_ready;
    logic [SW-1:0]    alloc_slot;
    logic             resolve_valid;
    logic [SW-1:0]    resolve_slot;
    logic             resolve_mispredict;
    logic [NFU-1:0]   pred_mask;
    logic [NFU-1:0]   hold;
    logic [NFU-1:0]   go_die;
    logic [NSLOT-1:0] slot_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    shadow_unit #(.NSLOT(NSLOT), .NFU(NFU)) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_fus(alloc_fus),
        .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .resolve_valid(resolve_valid), .resolve_slot(resolve_slot),
        .resolve_mispredict(resolve_mispredict), .pred_mask(pred_mask),
        .hold(hold), .go_die(go_die), .slot_busy(slot_busy)
    );

    // {kind, mispredict, fus, mask, expected go_die}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hFF, 8'hA5, 8'h5A},
        {1'b1, 1'b0, 8'h0F, 8'hFF, 8'h00},
        {1'b1, 1'b0, 8'hF0, 8'h00, 8'hF0},
        {1'b1, 1'b0, 8'h3C, 8'h0F, 8'h30},
        {1'b0, 1'b1, 8'h81, 8'hFF, 8'h81},
        {1'b0, 1'b0, 8'h7E, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'hFF, 8'h00, 8'hFF},
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; alloc_kind = 0; alloc_fus = '0;
        resolve_valid = 0; resolve_slot = '0; resolve_mispredict = 0; pred_mask = '0;
    endtask

    task automatic do_alloc(input logic k, input logic [NFU-1:0] f);
        alloc_valid = 1; alloc_kind = k; alloc_fus = f;
        step();
        alloc_valid = 0;
    endtask

    task automatic do_resolve(input logic [SW-1:0] sl, input logic mp, input logic [NFU-1:0] m);
        resolve_valid = 1; resolve_slot = sl; resolve_mispredict = mp; pred_mask = m;
        step();
        resolve_valid = 0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) step();
        rst = 0;
        check("R1 busy", 16'(slot_busy), 16'h0);
        check("R1 hold", 16'(hold), 16'h0);
        check("R1 go_die", 16'(go_die), 16'h0);
        check("R1 ready", 16'(alloc_ready), 16'h1);

        for (int v = 0; v < NVEC; v++) begin
            logic        k, mp;
            logic [7:0]  f, m, e;
            {k, mp, f, m, e} = VEC[v];
            alloc_valid = 1; alloc_kind = k; alloc_fus = f;
            check("R2 slot", 16'(alloc_slot), 16'h0);
            step();
            alloc_valid = 0;
            check("R3 hold", 16'(hold), 16'(f));
            check("R7 busy", 16'(slot_busy), 16'h1);
            do_resolve(0, mp, m);
            check(k ? "R4 die" : "R5 die", 16'(go_die), 16'(e));
            check("R7 hold", 16'(hold), 16'h0);
            check("R7 freed", 16'(slot_busy), 16'h0);
            step();
            check("R6 pulse", 16'(go_die), 16'h0);
        end

        // nested shadows, full, cross-cancel
        do_alloc(1'b0, 8'h0F);
        alloc_valid = 1; alloc_kind = 1; alloc_fus = 8'h3C;
        check("R2 second slot", 16'(alloc_slot), 16'h1);
        step();
        alloc_valid = 0;
        check("R3 or hold", 16'(hold), 16'h3F);
        check("R2 both busy", 16'(slot_busy), 16'h3);
        check("R2 not ready", 16'(alloc_ready), 16'h0);
        do_alloc(1'b1, 8'hC0);
        check("R2 full ignored hold", 16'(hold), 16'h3F);
        check("R2 full ignored busy", 16'(slot_busy), 16'h3);
        do_resolve(1, 0, 8'h04);
        check("R4 partial die", 16'(go_die), 16'h38);
        check("R9 dropped from other", 16'(hold), 16'h07);
        check("R7 slot1 freed", 16'(slot_busy), 16'h1);
        do_resolve(1, 1, 8'h00);
        check("R8 idle die", 16'(go_die), 16'h0);
        check("R8 idle hold", 16'(hold), 16'h07);
        check("R8 idle busy", 16'(slot_busy), 16'h1);
        do_resolve(0, 0, 8'h00);
        check("R5 release die", 16'(go_die), 16'h0);
        check("R5 release hold", 16'(hold), 16'h0);

        // release one overlapping shadow, other still holds
        do_alloc(1'b0, 8'h03);
        do_alloc(1'b0, 8'h06);
        do_resolve(0, 0, 8'h00);
        check("R3 still held", 16'(hold), 16'h06);
        check("R5 no die", 16'(go_die), 16'h0);
        do_resolve(1, 1, 8'hFF);
        check("R5 mispredict", 16'(go_die), 16'h06);
        check("R7 all free", 16'(slot_busy), 16'h0);

        // reset in the middle
        do_alloc(1'b1, 8'hAA);
        rst = 1;
        step();
        rst = 0;
        check("R1 mid busy", 16'(slot_busy), 16'h0);
        check("R1 mid hold", 16'(hold), 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule